// File: doc/BRIEF.md
# Two-Tier Graphics Port Error Logger

This block watches the request stream of a graphics port and the parity reports of its two read-return queues. It turns them into six error events and records those events in two 8-bit status registers. The first-error register captures only the earliest error, or every error detected in that same cycle. It then stays frozen until software has cleared every bit. The next-error register gathers all errors that arrive while the first-error register is occupied. It never receives the event that was captured as first.

A built-in tracker counts outstanding requests, up to a fixed limit, and flags a request that arrives when the count is full. It also flags a request whose upper address bits are not zero, a request that uses pipe mode while sideband addressing is enabled, and a request marked as an illegal command. Software reads either register through a one-bit-addressed port and clears bits by writing ones. Both registers keep their contents through the ordinary reset and clear only on power-on reset.

The capture control is a two-state machine. In `LOG_EMPTY` the first-error register holds nothing. The transition CAPTURE moves it to `LOG_HELD` when any event is detected. In `LOG_HELD` the first-error register is frozen. The transition RELEASE returns it to `LOG_EMPTY` once a write has cleared every remaining first-error bit.

Top module: `gfx_err_logger`

## Requirements
- R1: While `por_n` is low, both status registers read 00h and the outstanding count is zero.
- R2: The event bit positions, shared by both registers, are: bit 0 illegal command, bit 1 request overflow, bit 2 nonzero upper address, bit 3 pipe mode used with sideband enabled, bit 4 high-priority read queue parity error, bit 5 low-priority read queue parity error.
- R3: In `LOG_EMPTY`, every event detected in cycle t appears in `first_err` after the clock edge that ends cycle t, and `next_err` receives nothing from that cycle.
- R4: In `LOG_HELD`, new events never change `first_err`. Only write-one-to-clear writes change it.
- R5: In `LOG_HELD`, an event detected in cycle t is ORed into `next_err` at the edge that ends cycle t.
- R6: At most `MAX_OUT` (16) requests may be outstanding. A `req_valid` that arrives while 16 are outstanding raises event bit 1 and is not counted. A `req_done` decrements a nonzero count. When `req_valid` and `req_done` occur together, the count does not change.
- R7: Events at bits 0, 2 and 3 are raised only in a cycle with `req_valid` high. Bit 3 needs both `req_pipe` and `sb_en`. Bit 2 needs `req_addr_hi` to be nonzero.
- R8: A cycle with `reg_wr` high clears the bits of the addressed register where `reg_wdata` is 1 (`reg_addr` 0 selects first-error, 1 selects next-error). Bits written 0 are unchanged.
- R9: If a clear and a new event hit the same `next_err` bit in the same cycle, the bit ends up set.
- R10: After `first_err` is fully cleared (RELEASE), the next detected event is captured as a new first error.
- R11: Pulsing `rst_n` low empties the outstanding count and leaves both status registers unchanged.
- R12: `reg_rdata` shows the register selected by `reg_addr` in the same cycle, and bits 7:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous; clears only the request count |
| req_valid | input | 1 | A new request is presented this cycle |
| req_illegal | input | 1 | The presented request carries an illegal command |
| req_pipe | input | 1 | The presented request uses pipe mode |
| sb_en | input | 1 | Sideband addressing is enabled |
| req_addr_hi | input | 24 | Upper address bits of the presented request |
| req_done | input | 1 | One outstanding request completes this cycle |
| hp_par_err | input | 1 | Parity error on data from the high-priority read queue |
| lp_par_err | input | 1 | Parity error on data from the low-priority read queue |
| reg_wr | input | 1 | Register write strobe (write-one-to-clear) |
| reg_addr | input | 1 | Register select: 0 first-error, 1 next-error |
| reg_wdata | input | 8 | Write data; a 1 clears that bit |
| reg_rdata | output | 8 | Read data of the selected register |
| first_err | output | 8 | First-error register contents |
| next_err | output | 8 | Next-error register contents |

## Verification
Every status result is registered once. Events and clears presented in cycle t show up in `first_err` and `next_err` one clock edge later. The outstanding count changes on that same edge, so an overflow becomes visible one edge after the 17th request. `reg_rdata` is combinational from `reg_addr`, so it is checked within the same cycle. The bench drives every input on the falling edge and samples every result on the next falling edge, which is exactly one rising edge later. The vector table therefore pairs each row's stimulus directly with its expected register values.

// File: rtl/gel_pkg.sv
package gel_pkg;
    localparam int STAT_W = 8;
    localparam int EV_W   = 6;

    // event bit positions, decoded by software
    localparam int B_ILLEGAL = 0;
    localparam int B_OVF     = 1;
    localparam int B_ADDR    = 2;
    localparam int B_PIPE    = 3;
    localparam int B_HPPAR   = 4;
    localparam int B_LPPAR   = 5;

    localparam logic SEL_FIRST = 1'b0;
    localparam logic SEL_NEXT  = 1'b1;

    typedef enum logic {
        LOG_EMPTY = 1'b0,
        LOG_HELD  = 1'b1
    } log_state_e;
endpackage

// File: rtl/gel_req_tracker.sv
module gel_req_tracker #(
    parameter int MAX_OUT   = 16,
    parameter int ADDR_HI_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_illegal,
    input  logic                 req_pipe,
    input  logic                 sb_en,
    input  logic [ADDR_HI_W-1:0] req_addr_hi,
    input  logic                 req_done,
    output logic                 ev_illegal,
    output logic                 ev_ovf,
    output logic                 ev_addr,
    output logic                 ev_pipe
);
    localparam int               CNT_W = $clog2(MAX_OUT + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(MAX_OUT);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             full, accept, retire;

    always_comb begin
        full   = (cnt_q == FULL);
        accept = req_valid && !full;
        retire = req_done && (cnt_q != '0);
        cnt_d  = cnt_q;
        unique case ({accept, retire})
            2'b10:   cnt_d = cnt_q + ONE;
            2'b01:   cnt_d = cnt_q - ONE;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_comb begin
        ev_illegal = req_valid && req_illegal;
        ev_ovf     = req_valid && full;
        ev_addr    = req_valid && (req_addr_hi != '0);
        ev_pipe    = req_valid && req_pipe && sb_en;
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    // R6
    ovf_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && full && !req_done) |=> (cnt_q == FULL));
    // R6
    cnt_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && req_done && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/gel_first_next.sv
module gel_first_next
    import gel_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter int EW = EV_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic [EW-1:0] ev,
    input  logic [SW-1:0] clr_first,
    input  logic [SW-1:0] clr_next,
    output logic [SW-1:0] first_q,
    output logic [SW-1:0] next_q
);
    log_state_e    state_q, state_d;
    logic [SW-1:0] ev_w, first_kept, next_kept, first_d, next_d;

    assign ev_w       = {{(SW-EW){1'b0}}, ev};
    assign first_kept = first_q & ~clr_first;
    assign next_kept  = next_q & ~clr_next;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= LOG_EMPTY;
        else        state_q <= state_d;
    end

    // transitions and register contents
    always_comb begin
        state_d = state_q;
        first_d = first_kept;
        next_d  = next_kept;
        unique case (state_q)
            LOG_EMPTY: begin
                if (ev_w != '0) begin        // CAPTURE
                    state_d = LOG_HELD;
                    first_d = first_kept | ev_w;
                end
            end
            LOG_HELD: begin
                next_d = next_kept | ev_w;
                if (first_kept == '0)        // RELEASE
                    state_d = LOG_EMPTY;
            end
            default: state_d = LOG_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            first_q <= '0;
            next_q  <= '0;
        end else begin
            first_q <= first_d;
            next_q  <= next_d;
        end
    end

    // R4
    first_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == LOG_HELD && clr_first == '0) |=> $stable(first_q));
    // R3
    next_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == LOG_EMPTY && ev != '0) |=> (next_q == ($past(next_q) & ~$past(clr_next))));
    // R10
    state_match_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == LOG_HELD) == (first_q != '0));
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == LOG_HELD && (ev_w & clr_next) != '0)
        |=> ((next_q & $past(ev_w & clr_next)) == $past(ev_w & clr_next)));
endmodule

// File: rtl/gel_regif.sv
module gel_regif
    import gel_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter int EW = EV_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          reg_wr,
    input  logic          reg_addr,
    input  logic [SW-1:0] reg_wdata,
    input  logic [SW-1:0] first_q,
    input  logic [SW-1:0] next_q,
    output logic [SW-1:0] clr_first,
    output logic [SW-1:0] clr_next,
    output logic [SW-1:0] reg_rdata
);
    localparam logic [SW-1:0] RD_MASK = {{(SW-EW){1'b0}}, {EW{1'b1}}};

    always_comb begin
        clr_first = (reg_wr && reg_addr == SEL_FIRST) ? reg_wdata : '0;
        clr_next  = (reg_wr && reg_addr == SEL_NEXT)  ? reg_wdata : '0;
        reg_rdata = ((reg_addr == SEL_NEXT) ? next_q : first_q) & RD_MASK;
    end

    // R12
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (first_q & ~RD_MASK) == '0 && (next_q & ~RD_MASK) == '0);
endmodule

// File: rtl/gfx_err_logger.sv
module gfx_err_logger
    import gel_pkg::*;
#(
    parameter int MAX_OUT   = 16,
    parameter int ADDR_HI_W = 24
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_illegal,
    input  logic                 req_pipe,
    input  logic                 sb_en,
    input  logic [ADDR_HI_W-1:0] req_addr_hi,
    input  logic                 req_done,
    input  logic                 hp_par_err,
    input  logic                 lp_par_err,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [STAT_W-1:0]    reg_wdata,
    output logic [STAT_W-1:0]    reg_rdata,
    output logic [STAT_W-1:0]    first_err,
    output logic [STAT_W-1:0]    next_err
);
    logic              trk_rst_n;
    logic              ev_illegal, ev_ovf, ev_addr, ev_pipe;
    logic [EV_W-1:0]   ev;
    logic [STAT_W-1:0] clr_first, clr_next;

    assign trk_rst_n = rst_n & por_n;

    gel_req_tracker #(
        .MAX_OUT   (MAX_OUT),
        .ADDR_HI_W (ADDR_HI_W)
    ) u_trk (
        .clk         (clk),
        .rst_n       (trk_rst_n),
        .req_valid   (req_valid),
        .req_illegal (req_illegal),
        .req_pipe    (req_pipe),
        .sb_en       (sb_en),
        .req_addr_hi (req_addr_hi),
        .req_done    (req_done),
        .ev_illegal  (ev_illegal),
        .ev_ovf      (ev_ovf),
        .ev_addr     (ev_addr),
        .ev_pipe     (ev_pipe)
    );

    always_comb begin
        ev            = '0;
        ev[B_ILLEGAL] = ev_illegal;
        ev[B_OVF]     = ev_ovf;
        ev[B_ADDR]    = ev_addr;
        ev[B_PIPE]    = ev_pipe;
        ev[B_HPPAR]   = hp_par_err;
        ev[B_LPPAR]   = lp_par_err;
    end

    gel_first_next #(
        .SW (STAT_W),
        .EW (EV_W)
    ) u_log (
        .clk       (clk),
        .por_n     (por_n),
        .ev        (ev),
        .clr_first (clr_first),
        .clr_next  (clr_next),
        .first_q   (first_err),
        .next_q    (next_err)
    );

    gel_regif #(
        .SW (STAT_W),
        .EW (EV_W)
    ) u_reg (
        .clk       (clk),
        .por_n     (por_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .first_q   (first_err),
        .next_q    (next_err),
        .clr_first (clr_first),
        .clr_next  (clr_next),
        .reg_rdata (reg_rdata)
    );

    // R11
    warm_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && !req_valid && !hp_par_err && !lp_par_err && !reg_wr)
        |=> ($stable(first_err) && $stable(next_err)));
endmodule

// File: tb/gfx_err_logger_tb.sv
`timescale 1ns/1ps
module gfx_err_logger_tb;
    logic        clk = 1'b0;
    logic        por_n, rst_n;
    logic        req_valid, req_illegal, req_pipe, sb_en, req_done;
    logic [23:0] req_addr_hi;
    logic        hp_par_err, lp_par_err;
    logic        reg_wr, reg_addr;
    logic [7:0]  reg_wdata, reg_rdata, first_err, next_err;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    gfx_err_logger u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .req_valid(req_valid), .req_illegal(req_illegal), .req_pipe(req_pipe),
        .sb_en(sb_en), .req_addr_hi(req_addr_hi), .req_done(req_done),
        .hp_par_err(hp_par_err), .lp_par_err(lp_par_err),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .first_err(first_err), .next_err(next_err)
    );

    // row: {valid,illegal,addrnz,pipe,sb,hp,lp}, wr, addr, wdata, exp_first, exp_next
    localparam int NV = 14;
    localparam logic [32:0] TBL [NV] = '{
        {7'b0000000, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00}, // idle
        {7'b1100000, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00}, // R3 capture illegal
        {7'b0000010, 1'b0, 1'b0, 8'h00, 8'h01, 8'h10}, // R5 hp parity to next
        {7'b1100000, 1'b0, 1'b0, 8'h00, 8'h01, 8'h11}, // R4 first held
        {7'b0000000, 1'b1, 1'b1, 8'h10, 8'h01, 8'h01}, // R8 clear next bit4
        {7'b0000000, 1'b1, 1'b0, 8'h00, 8'h01, 8'h01}, // R8 zero write no effect
        {7'b1100000, 1'b1, 1'b1, 8'h01, 8'h01, 8'h01}, // R9 set wins
        {7'b0000000, 1'b1, 1'b0, 8'h01, 8'h00, 8'h01}, // R10 release
        {7'b1010001, 1'b0, 1'b0, 8'h00, 8'h24, 8'h01}, // R2 two events as first
        {7'b1001100, 1'b0, 1'b0, 8'h00, 8'h24, 8'h09}, // R7 pipe with sideband
        {7'b1001000, 1'b0, 1'b0, 8'h00, 8'h24, 8'h09}, // R7 pipe, no sideband
        {7'b0001100, 1'b0, 1'b0, 8'h00, 8'h24, 8'h09}, // R7 no valid
        {7'b0000000, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h09}, // R8 clear first
        {7'b0000000, 1'b1, 1'b1, 8'hFF, 8'h00, 8'h00}  // R8 clear next
    };

    function automatic string row_tag(int i);
        case (i)
            1:        return "R3";
            2:        return "R5";
            3:        return "R4";
            6:        return "R9";
            7:        return "R10";
            8:        return "R2";
            9, 10, 11: return "R7";
            default:  return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(logic v, logic ill, logic anz, logic pp, logic sb,
                         logic hp, logic lp, logic dn,
                         logic wr, logic ad, logic [7:0] wd);
        req_valid   = v;   req_illegal = ill;
        req_addr_hi = anz ? 24'h000100 : 24'h0;
        req_pipe    = pp;  sb_en = sb;
        hp_par_err  = hp;  lp_par_err = lp;
        req_done    = dn;
        reg_wr      = wr;  reg_addr = ad;  reg_wdata = wd;
        @(negedge clk);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic req();
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b0;
        req_valid = 0; req_illegal = 0; req_pipe = 0; sb_en = 0; req_done = 0;
        req_addr_hi = '0; hp_par_err = 0; lp_par_err = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 first", first_err, 8'h00);
        check("R1 next", next_err, 8'h00);
        check("R1 rdata", reg_rdata, 8'h00);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i][32], TBL[i][31], TBL[i][30], TBL[i][29], TBL[i][28],
                  TBL[i][27], TBL[i][26], 1'b1, TBL[i][25], TBL[i][24], TBL[i][23:16]);
            check({row_tag(i), " first"}, first_err, TBL[i][15:8]);
            check({row_tag(i), " next"}, next_err, TBL[i][7:0]);
        end

        // R6: sixteen outstanding are accepted silently
        idle();
        repeat (16) req();
        check("R6 full no error", first_err, 8'h00);
        req();
        check("R6 overflow first", first_err, 8'h02);
        check("R6 overflow next", next_err, 8'h00);
        req();
        check("R6 overflow not counted", next_err, 8'h02);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 8'hFF);
        check("R8 clear next", next_err, 8'h00);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h00);
        req();
        check("R6 slot freed", next_err, 8'h00);
        req();
        check("R6 full again", next_err, 8'h02);

        // R11: ordinary reset empties count, keeps status
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 8'hFF);
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        check("R11 first kept", first_err, 8'h02);
        check("R11 next kept", next_err, 8'h00);
        repeat (16) req();
        check("R11 count emptied", next_err, 8'h00);
        req();
        check("R11 overflow after 16", next_err, 8'h02);

        // R12 read port
        idle();
        reg_addr = 1'b0; #1;
        check("R12 read first", reg_rdata, 8'h02);
        reg_addr = 1'b1; #1;
        check("R12 read next", reg_rdata, 8'h02);
        check("R12 reserved bits", {6'b0, reg_rdata[7:6]}, 8'h00);
        @(negedge clk);

        // R1 power-on reset clears sticky bits
        por_n = 1'b0;
        #1;
        check("R1 por first", first_err, 8'h00);
        check("R1 por next", next_err, 8'h00);
        @(negedge clk);
        finish_run();
    end
endmodule